// File: doc/BRIEF.md
# Receive and Transmit DMA Request Controller

This block decides when a network controller asks its bus master for receive and transmit DMA service. On the transmit side it compares the free space of the transmit FIFO against a watermark chosen by a 2-bit select, and raises the transmit request whenever enough room is free. The duplex setting has no effect on the transmit side.

On the receive side it compares the receive FIFO fill level against a second watermark. It also follows frame progress through a start strobe, a per-byte write strobe and an end strobe that carries a good/bad flag.

In half-duplex operation the block normally holds back the request for a new frame until that frame has delivered a minimum number of bytes. Collision fragments therefore never reach memory. The hold is lifted in full-duplex mode, and also in half-duplex mode when the runt-accept input is set. In either of those cases, any frame that completes well raises a request, whatever its length.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_n is low both request outputs are low, whatever the other inputs are.
- R2: The transmit request is registered. One clock edge after tx_space is greater than or equal to the transmit watermark it is high, and otherwise it is low. The transmit watermark select codes are 00=16, 01=64, 10=108 and 11=64 bytes. Neither the duplex nor the runt-accept input changes the transmit request.
- R3: The receive watermark select codes are 00=16, 01=64, 10=112 and 11=64 bytes.
- R4: In relaxed mode (full_duplex=1, or runt_accept=1), the receive request is high one clock edge after rx_count is greater than or equal to the receive watermark.
- R5: In relaxed mode, a frame_end strobe with frame_ok=1 raises the receive request on the second clock edge after the strobe, for a frame of any length. A frame_end strobe with frame_ok=0 raises no request.
- R6: In strict mode (full_duplex=0 and runt_accept=0), a frame_start strobe blocks requests from the receive watermark. The block lasts until 64 rx_wr strobes have been counted since that frame_start.
- R7: In strict mode, once 64 bytes of the current frame are counted, the receive watermark once again raises the request one edge after it is reached.
- R8: In strict mode, a good frame end raises the request on the second edge after the strobe only if the frame had 64 or more bytes. A shorter frame is treated as flushed and never raises a request.
- R9: A completed frame stays pending until rx_count reads 0. The receive request falls on the first edge at which rx_count is below the watermark and no frame is pending.
- R10: A pending completed frame keeps the receive request high while a later frame is held back by the strict-mode byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | CNT_W | Bytes currently held in the receive FIFO |
| rx_wr | input | 1 | One byte of the current frame written to the receive FIFO |
| frame_start | input | 1 | A new receive frame begins |
| frame_end | input | 1 | The current receive frame has ended |
| frame_ok | input | 1 | Qualifies frame_end: frame received without error |
| tx_space | input | CNT_W | Free bytes in the transmit FIFO |
| full_duplex | input | 1 | 1 selects full-duplex operation |
| runt_accept | input | 1 | 1 lifts the minimum-length hold in half-duplex |
| rx_wm_sel | input | 2 | Receive watermark select |
| tx_wm_sel | input | 2 | Transmit watermark select |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The assertions rely on three properties of the inputs:
- frame_start never shares a cycle with rx_wr or frame_end.
- rx_count only reads 0 when the FIFO truly holds no frame.
- Frame strobes last exactly one cycle.

The stimulus respects all three. It opens each frame with a lone start pulse, then writes one byte per cycle while raising rx_count in step. It ends the frame with a one-cycle end pulse that carries no byte write, and returns rx_count to 0 only when it drains the FIFO between scenarios.

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int CNT_W      = 11,
  parameter int HOLD_BYTES = 64,
  parameter int RX_WM0     = 16,
  parameter int RX_WM1     = 64,
  parameter int RX_WM2     = 112,
  parameter int TX_WM0     = 16,
  parameter int TX_WM1     = 64,
  parameter int TX_WM2     = 108
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_wr,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             frame_ok,
  input  logic [CNT_W-1:0] tx_space,
  input  logic             full_duplex,
  input  logic             runt_accept,
  input  logic [1:0]       rx_wm_sel,
  input  logic [1:0]       tx_wm_sel,
  output logic             rx_dma_req,
  output logic             tx_dma_req
);
  localparam int FC_W = $clog2(HOLD_BYTES + 1);

  logic [CNT_W-1:0] rx_wm, tx_wm;
  logic [FC_W-1:0]  fcnt;
  logic             hold_q, pend_q;
  logic             strict, fcnt_full, hold, pend_live;

  always_comb begin
    case (rx_wm_sel)
      2'd0:    rx_wm = CNT_W'(RX_WM0);
      2'd2:    rx_wm = CNT_W'(RX_WM2);
      default: rx_wm = CNT_W'(RX_WM1);
    endcase
    case (tx_wm_sel)
      2'd0:    tx_wm = CNT_W'(TX_WM0);
      2'd2:    tx_wm = CNT_W'(TX_WM2);
      default: tx_wm = CNT_W'(TX_WM1);
    endcase
  end

  assign strict    = !full_duplex && !runt_accept;
  assign fcnt_full = (fcnt == FC_W'(HOLD_BYTES));
  assign hold      = strict && hold_q && !fcnt_full;
  assign pend_live = pend_q && (rx_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt       <= '0;
      hold_q     <= 1'b0;
      pend_q     <= 1'b0;
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      if (frame_start) begin
        fcnt   <= '0;
        hold_q <= 1'b1;
      end else if (rx_wr && !fcnt_full) begin
        fcnt <= fcnt + 1'b1;
      end
      if (frame_end && frame_ok && (!strict || fcnt_full))
        pend_q <= 1'b1;
      else if (rx_count == '0)
        pend_q <= 1'b0;
      rx_dma_req <= pend_live || (!hold && rx_count >= rx_wm);
      tx_dma_req <= tx_space >= tx_wm;
    end
  end

  // R1: outputs low in the cycle following a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !rx_dma_req && !tx_dma_req);

  // R2: large free space always requests, tiny free space never does
  a_r2_tx_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_space >= CNT_W'(TX_WM2) |=> tx_dma_req);
  a_r2_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_space < CNT_W'(TX_WM0) |=> !tx_dma_req);

  // R4: relaxed mode, fill above every watermark must request
  a_r4_relaxed_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!strict && rx_count >= CNT_W'(RX_WM2)) |=> rx_dma_req);

  // R9: an empty receive FIFO never leaves a request standing
  a_r9_empty_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |=> !rx_dma_req);

  // R6: a fresh strict-mode frame with nothing pending cannot request
  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (strict && hold && !pend_live) |=> !rx_dma_req);
endmodule

// File: tb/test_dma_req_ctrl.sv
module test_dma_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, tx_space = '0;
  logic rx_wr = 0, frame_start = 0, frame_end = 0, frame_ok = 0;
  logic full_duplex = 0, runt_accept = 0;
  logic [1:0] rx_wm_sel = 0, tx_wm_sel = 0;
  logic rx_dma_req, tx_dma_req;
  int checks = 0, failures = 0;

  // {is_tx, sel, count, expected}
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 2'd0, 11'd15,  1'b0}, {1'b0, 2'd0, 11'd16,  1'b1},
    {1'b0, 2'd1, 11'd63,  1'b0}, {1'b0, 2'd1, 11'd64,  1'b1},
    {1'b0, 2'd2, 11'd111, 1'b0}, {1'b0, 2'd2, 11'd112, 1'b1},
    {1'b0, 2'd3, 11'd63,  1'b0}, {1'b0, 2'd3, 11'd64,  1'b1},
    {1'b1, 2'd0, 11'd15,  1'b0}, {1'b1, 2'd0, 11'd16,  1'b1},
    {1'b1, 2'd1, 11'd63,  1'b0}, {1'b1, 2'd1, 11'd64,  1'b1},
    {1'b1, 2'd2, 11'd107, 1'b0}, {1'b1, 2'd2, 11'd108, 1'b1},
    {1'b1, 2'd3, 11'd63,  1'b0}, {1'b1, 2'd3, 11'd64,  1'b1}
  };

  dma_req_ctrl i_dma_req_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_wr(rx_wr),
    .frame_start(frame_start), .frame_end(frame_end), .frame_ok(frame_ok),
    .tx_space(tx_space), .full_duplex(full_duplex), .runt_accept(runt_accept),
    .rx_wm_sel(rx_wm_sel), .tx_wm_sel(tx_wm_sel),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic start_frame();
    frame_start = 1; tick(); frame_start = 0;
  endtask

  task automatic send(input int first, input int last, input int base);
    for (int b = first; b <= last; b++) begin
      rx_wr = 1; rx_count = CNT_W'(base + b); tick();
    end
    rx_wr = 0;
  endtask

  task automatic end_frame(input logic ok);
    frame_end = 1; frame_ok = ok; tick();
    frame_end = 0; frame_ok = 0;
  endtask

  task automatic drain();
    rx_count = '0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    // R1: reset with inputs that would otherwise request
    full_duplex = 1; rx_count = 11'd500; tx_space = 11'd500;
    tick(); tick();
    check(rx_dma_req, 1'b0, "R1 rx during reset");
    check(tx_dma_req, 1'b0, "R1 tx during reset");
    rst_n = 1; rx_count = '0; tx_space = '0; tick();

    // R2 R3 R4: watermark decode table, relaxed mode
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][14]) begin
        tx_wm_sel = VEC[i][13:12]; tx_space = VEC[i][11:1]; tick();
        check(tx_dma_req, VEC[i][0], "R2 tx watermark");
        full_duplex = 0; tick();
        check(tx_dma_req, VEC[i][0], "R2 tx duplex independent");
        full_duplex = 1;
      end else begin
        rx_wm_sel = VEC[i][13:12]; rx_count = VEC[i][11:1]; tick();
        check(rx_dma_req, VEC[i][0], "R3 R4 rx watermark");
      end
    end
    tx_space = '0; drain();

    // R6 R8: strict, 40-byte good frame, low watermark
    full_duplex = 0; runt_accept = 0; rx_wm_sel = 2'd0;
    start_frame(); send(1, 40, 0);
    check(rx_dma_req, 1'b0, "R6 held below 64 bytes");
    end_frame(1); tick(); tick();
    check(rx_dma_req, 1'b0, "R8 short frame flushed");
    drain();

    // R8 R9: strict, 64-byte good frame, watermark 112
    rx_wm_sel = 2'd2;
    start_frame(); send(1, 64, 0);
    check(rx_dma_req, 1'b0, "R8 64 bytes below watermark");
    end_frame(1);
    check(rx_dma_req, 1'b0, "R8 first edge after end");
    tick();
    check(rx_dma_req, 1'b1, "R8 second edge after end");

    // R10: next frame held, earlier frame still pending
    start_frame(); send(1, 10, 64);
    check(rx_dma_req, 1'b1, "R10 pending frame keeps request");
    drain();
    check(rx_dma_req, 1'b0, "R9 drop on empty");

    // R7: strict, 1518-byte frame, watermark 112
    start_frame(); send(1, 111, 0);
    check(rx_dma_req, 1'b0, "R7 below watermark");
    send(112, 112, 0);
    check(rx_dma_req, 1'b1, "R7 watermark reached");
    send(113, 1518, 0);
    end_frame(1); tick();
    check(rx_dma_req, 1'b1, "R7 long frame request");
    drain();
    check(rx_dma_req, 1'b0, "R9 drop after long frame");

    // R6: strict, watermark 16 reached inside the first 64 bytes
    rx_wm_sel = 2'd0;
    start_frame(); send(1, 64, 0);
    check(rx_dma_req, 1'b0, "R6 hold at 64th byte edge");
    send(65, 65, 0);
    check(rx_dma_req, 1'b1, "R7 released after 64 bytes");
    drain();

    // R4 R5: full duplex, 40-byte frame
    full_duplex = 1; rx_wm_sel = 2'd0;
    start_frame(); send(1, 15, 0);
    check(rx_dma_req, 1'b0, "R4 below 16");
    send(16, 16, 0);
    check(rx_dma_req, 1'b1, "R4 reached 16 full duplex");
    send(17, 40, 0); drain();
    rx_wm_sel = 2'd2;
    start_frame(); send(1, 40, 0);
    end_frame(1);
    check(rx_dma_req, 1'b0, "R5 first edge after end");
    tick();
    check(rx_dma_req, 1'b1, "R5 short frame full duplex");
    drain();

    // R5: bad frame end raises nothing
    start_frame(); send(1, 40, 0);
    end_frame(0); tick(); tick();
    check(rx_dma_req, 1'b0, "R5 bad frame");
    drain();

    // R5: runt-accept in half duplex, 40 bytes
    full_duplex = 0; runt_accept = 1;
    start_frame(); send(1, 40, 0);
    end_frame(1); tick();
    check(rx_dma_req, 1'b1, "R5 runt accept short frame");

    // R9: request falls one edge after level drops below watermark
    drain();
    rx_wm_sel = 2'd1; rx_count = 11'd64; tick();
    check(rx_dma_req, 1'b1, "R9 at watermark");
    rx_count = 11'd63; tick();
    check(rx_dma_req, 1'b0, "R9 below watermark");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule